// File: doc/BRIEF.md
# Game Pad Shift-Register Responder

This block answers a host that polls a game pad over two shared fire lines. While the host holds its select line high, both fire lines act as ordinary active-low button outputs. When the host pulls select low, the block hands the first fire line over to the host, which uses it as a shift clock. The block then drives a 16-bit reply serially on the second fire line.

The reply is kept ready in a register that follows the parallel button input from the upstream pad reader. Starting a frame therefore only copies that register into the shifter. The first button bit appears on the data line as soon as the falling select edge has passed the synchronizer, with no wait for any clock edge. Every later bit is advanced by a rising edge of the host clock.

All host signals are sampled with a fast system clock, which must run at least 8 times faster than the host shift clock. Each host signal passes through a two-flop synchronizer and then an edge detector.

Top module: `gamepad_shift_responder`

## Requirements
- R1: While no frame is active, both fire pins are driven as outputs (`fire1_oe` = 1, `fire2_oe` = 1), with `fire1_out` = ~`btn_state[1]` and `fire2_out` = ~`btn_state[0]` (a pressed button reads 0).
- R2: Three system clocks after `host_sel_n` falls, a frame starts. `fire1_oe` goes to 0, `fire2_oe` stays 1, and `fire2_out` shows reply bit 15, with no host clock edge needed. The reply is built from the buttons present when select falls.
- R3: The reply goes out most significant bit first. Bits 15 down to 9 are ~`btn_state[0]` through ~`btn_state[6]`. Bits 8 down to 0 are the parameter `ID_PATTERN`, MSB first. Each rising edge of `host_sclk` during a frame moves `fire2_out` to the next bit, three system clocks after the edge. Falling edges of `host_sclk` change nothing.
- R4: The reply is captured when the frame starts. Changes of `btn_state` during the frame do not alter the bits being shifted.
- R5: After 15 advances, `fire2_out` holds bit 0 for any further rising edges in the same frame.
- R6: Rising edges of `host_sclk` while `host_sel_n` is high are ignored. A frame started afterwards still begins at bit 15.
- R7: When `host_sel_n` returns high, the frame is abandoned and the pins return to R1 behaviour three system clocks later. The next frame starts again at bit 15.
- R8: The level of `host_sclk` when select falls does not matter. Only rising edges seen after the frame start advance the shifter. A rising edge detected in the same cycle as the frame start loses to the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| host_sel_n | input | 1 | host select line, low during polling |
| host_sclk | input | 1 | host shift clock, taken from the first fire pin |
| btn_state | input | 7 | button states, 1 = pressed; bit 0 is sent first |
| fire1_oe | output | 1 | drive enable of the first fire pin (0 = pin is the clock input) |
| fire1_out | output | 1 | value driven on the first fire pin |
| fire2_oe | output | 1 | drive enable of the second fire pin |
| fire2_out | output | 1 | value on the second fire pin: button or serial data |

## Verification
The hardest case to reach is a collision of host events with the frame boundaries. Examples are a host clock that is already high when select falls, button changes in the middle of a frame, and more clock edges than the word holds. The driver reaches these by setting the select line, the host clock and the buttons independently at exact cycles. It can hold the clock high across the select edge, change the buttons after a few edges, and run past 16 edges. It also abandons a frame midway and checks that the next frame restarts at the first bit.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } gp_edge_t;
endpackage

// File: rtl/gp_sync.sv
module gp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else if (i == 0) stage_q[i] <= d_in;
        else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gp_edge.sv
module gp_edge
  import gp_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     level_in,
  output gp_edge_t ev
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_in;
  end

  always_comb begin
    ev.level = level_in;
    ev.rise  = level_in & ~prev_q;
    ev.fall  = ~level_in & prev_q;
  end
endmodule

// File: rtl/gp_reply.sv
module gp_reply #(
  parameter int WORD_W  = 16,
  parameter int BTN_N   = 7,
  parameter int ID_W    = WORD_W - BTN_N,
  parameter logic [ID_W-1:0] ID_PATTERN = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BTN_N-1:0]  btn_state,
  output logic [WORD_W-1:0] reply_q
);
  function automatic logic [WORD_W-1:0] build_reply(input logic [BTN_N-1:0] b);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < BTN_N; i++) w[WORD_W-1-i] = ~b[i];
    w[ID_W-1:0] = ID_PATTERN;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reply_q <= build_reply('0);
    else        reply_q <= build_reply(btn_state);
  end
endmodule

// File: rtl/gp_shifter.sv
module gp_shifter
  import gp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gp_edge_t          sel_ev,
  input  gp_edge_t          sclk_ev,
  input  logic [WORD_W-1:0] reply_q,
  output logic              active,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              data_bit
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q;
  logic              frame_start, frame_stop, advance;

  assign frame_start = sel_ev.fall;
  assign frame_stop  = sel_ev.rise;
  assign advance     = active && sclk_ev.rise && (bit_cnt != LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      shreg_q <= '0;
      bit_cnt <= '0;
    end else if (frame_start) begin
      active  <= 1'b1;
      shreg_q <= reply_q;
      bit_cnt <= '0;
    end else if (frame_stop) begin
      active  <= 1'b0;
    end else if (advance) begin
      shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign data_bit = shreg_q[WORD_W-1];
endmodule

// File: rtl/gamepad_shift_responder.sv
module gamepad_shift_responder
  import gp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int BTN_N       = 7,
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = WORD_W - BTN_N,
  parameter logic [ID_W-1:0] ID_PATTERN = 9'h0A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sel_n,
  input  logic             host_sclk,
  input  logic [BTN_N-1:0] btn_state,
  output logic             fire1_oe,
  output logic             fire1_out,
  output logic             fire2_oe,
  output logic             fire2_out
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              sel_s, sclk_s;
  gp_edge_t          sel_ev, sclk_ev;
  logic [WORD_W-1:0] reply_q;
  logic              active, data_bit;
  logic [CNT_W-1:0]  bit_cnt;
  logic              mode_fall, mode_rise, sclk_rise;

  gp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d_in(host_sel_n), .q_out(sel_s));
  gp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_in(host_sclk), .q_out(sclk_s));

  gp_edge #(.RST_VAL(1'b1)) u_edge_sel (
    .clk(clk), .rst_n(rst_n), .level_in(sel_s), .ev(sel_ev));
  gp_edge #(.RST_VAL(1'b0)) u_edge_sclk (
    .clk(clk), .rst_n(rst_n), .level_in(sclk_s), .ev(sclk_ev));

  gp_reply #(.WORD_W(WORD_W), .BTN_N(BTN_N), .ID_W(ID_W), .ID_PATTERN(ID_PATTERN)) u_reply (
    .clk(clk), .rst_n(rst_n), .btn_state(btn_state), .reply_q(reply_q));

  gp_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sel_ev(sel_ev), .sclk_ev(sclk_ev),
    .reply_q(reply_q), .active(active), .bit_cnt(bit_cnt), .data_bit(data_bit));

  assign mode_fall = sel_ev.fall;
  assign mode_rise = sel_ev.rise;
  assign sclk_rise = sclk_ev.rise;

  assign fire1_oe  = ~active;
  assign fire1_out = ~btn_state[1];
  assign fire2_oe  = 1'b1;
  assign fire2_out = active ? data_bit : ~btn_state[0];
endmodule

// File: rtl/gp_responder_checker.sv
module gp_responder_checker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_fall,
  input logic              mode_rise,
  input logic              sclk_rise,
  input logic              active,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] reply_q,
  input logic              fire1_oe,
  input logic              fire2_out
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fall |=> (!fire1_oe && fire2_out == $past(reply_q[WORD_W-1]))); // R2
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sclk_rise && !mode_fall && !mode_rise && bit_cnt != LAST_IDX)
      |=> bit_cnt == $past(bit_cnt) + 1'b1); // R3
  AST_FROZEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sclk_rise && !mode_fall && !mode_rise) |=> $stable(fire2_out)); // R4
  AST_HOLD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_cnt == LAST_IDX && !mode_fall && !mode_rise)
      |=> (bit_cnt == LAST_IDX && $stable(fire2_out))); // R5
  AST_IGNORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && sclk_rise && !mode_fall) |=> !active); // R6
  AST_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rise && !mode_fall) |=> fire1_oe); // R7
endmodule

bind gamepad_shift_responder gp_responder_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_fall(mode_fall), .mode_rise(mode_rise),
  .sclk_rise(sclk_rise), .active(active), .bit_cnt(bit_cnt), .reply_q(reply_q),
  .fire1_oe(fire1_oe), .fire2_out(fire2_out));

// File: tb/tb_gamepad_shift_responder.sv
module tb_gamepad_shift_responder;
  localparam logic [8:0] ID = 9'h0A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel_n = 1'b1;
  logic host_sclk = 1'b0;
  logic [6:0] btn = '0;
  logic fire1_oe, fire1_out, fire2_oe, fire2_out;

  always #2 clk = ~clk;

  gamepad_shift_responder dut (
    .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_sclk(host_sclk),
    .btn_state(btn), .fire1_oe(fire1_oe), .fire1_out(fire1_out),
    .fire2_oe(fire2_oe), .fire2_out(fire2_out));

  typedef struct {
    int         due;
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reply bit k (k = 0 is sent first): buttons active-low, then ID MSB first
  function automatic logic exp_bit(input logic [6:0] b, input int k);
    if (k < 7) return ~b[k];
    return ID[8 - (k - 7)];
  endfunction
  function automatic logic [3:0] idle_exp(input logic [6:0] b);
    return {1'b1, ~b[1], 1'b1, ~b[0]};
  endfunction
  function automatic logic [3:0] frame_exp(input logic [6:0] b, input logic d);
    return {1'b0, ~b[1], 1'b1, d};
  endfunction

  // monitor: compares the front of the scoreboard once its sample cycle arrives
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [3:0] act;
        it  = sb.pop_front();
        act = {fire1_oe, fire1_out, fire2_oe, fire2_out};
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: pins actual %b expected %b at cycle %0d", it.tag, act, it.exp, cyc);
        end
      end
    end
  end

  // driver: apply inputs at a negedge, schedule expectation 4 clocks later
  task automatic act(input logic m, input logic s, input logic [6:0] b,
                     input logic [3:0] e, input string tag);
    host_sel_n = m;
    host_sclk  = s;
    btn        = b;
    sb.push_back('{cyc + 4, e, tag});
    repeat (6) @(negedge clk);
  endtask

  // full frame: n rising edges, optional button swap after edge swap_at
  task automatic frame(input logic [6:0] a, input int n, input int swap_at,
                       input logic [6:0] bnew, input string tag);
    logic [6:0] cur;
    int idx;
    cur = a;
    act(1'b0, 1'b0, cur, frame_exp(cur, exp_bit(a, 0)), "R2 first bit");
    for (int k = 1; k <= n; k++) begin
      if (k == swap_at) cur = bnew;
      idx = (k > 15) ? 15 : k;
      act(1'b0, 1'b1, cur, frame_exp(cur, exp_bit(a, idx)), (k > 15) ? "R5 hold" : tag);
      act(1'b0, 1'b0, cur, frame_exp(cur, exp_bit(a, idx)), "R3 fall no change");
    end
    act(1'b1, 1'b0, cur, idle_exp(cur), "R7 end frame");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset / idle state
    act(1'b1, 1'b0, 7'b0000000, idle_exp(7'b0000000), "R1 reset idle");
    act(1'b1, 1'b0, 7'b0000011, idle_exp(7'b0000011), "R1 idle pressed");
    act(1'b1, 1'b0, 7'b0000010, idle_exp(7'b0000010), "R1 idle red only");
    // R2/R3: two button patterns, buttons change together with select fall
    frame(7'b1010011, 16, 0, '0, "R3 shift");
    frame(7'b0101100, 16, 0, '0, "R3 shift alt");
    // R5: extra edges
    frame(7'b1110001, 20, 0, '0, "R3 shift pre-hold");
    // R4: buttons change mid-frame
    frame(7'b0011010, 10, 3, 7'b1100101, "R4 frozen reply");
    // R6: clock pulses with select high are ignored
    for (int k = 0; k < 3; k++) begin
      act(1'b1, 1'b1, 7'b1000001, idle_exp(7'b1000001), "R6 idle clock high");
      act(1'b1, 1'b0, 7'b1000001, idle_exp(7'b1000001), "R6 idle clock low");
    end
    act(1'b0, 1'b0, 7'b1000001, frame_exp(7'b1000001, exp_bit(7'b1000001, 0)), "R6 starts at first bit");
    act(1'b0, 1'b1, 7'b1000001, frame_exp(7'b1000001, exp_bit(7'b1000001, 1)), "R6 then second bit");
    // R7: abandon mid-frame, next frame restarts
    act(1'b1, 1'b1, 7'b1000001, idle_exp(7'b1000001), "R7 abandon");
    act(1'b1, 1'b0, 7'b1000001, idle_exp(7'b1000001), "R7 idle after abandon");
    act(1'b0, 1'b0, 7'b1000001, frame_exp(7'b1000001, exp_bit(7'b1000001, 0)), "R7 restart first bit");
    act(1'b1, 1'b0, 7'b1000001, idle_exp(7'b1000001), "R7 idle");
    // R8: clock already high when select falls
    act(1'b1, 1'b1, 7'b0110110, idle_exp(7'b0110110), "R8 clock high idle");
    act(1'b0, 1'b1, 7'b0110110, frame_exp(7'b0110110, exp_bit(7'b0110110, 0)), "R8 first bit with clock high");
    act(1'b0, 1'b0, 7'b0110110, frame_exp(7'b0110110, exp_bit(7'b0110110, 0)), "R8 fall no advance");
    act(1'b0, 1'b1, 7'b0110110, frame_exp(7'b0110110, exp_bit(7'b0110110, 1)), "R8 first rise advances");
    // R8: clock rise and select fall in the same cycle, load wins
    act(1'b1, 1'b0, 7'b0110110, idle_exp(7'b0110110), "R8 idle");
    act(1'b0, 1'b1, 7'b0001111, frame_exp(7'b0001111, exp_bit(7'b0001111, 0)), "R8 coincident edges");
    act(1'b1, 1'b0, 7'b0001111, idle_exp(7'b0001111), "R1 final idle");
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule